// File: doc/BRIEF.md
# Resonant-link inverter gate sequencer

This block turns three raw PWM leg commands into gate drives for a three-phase bridge fed through a series link switch that sits in front of a resonant dc link. Each leg command comes from comparing a sawtooth carrier against one of three sine references spaced 120 degrees apart. The bridge may only commutate while the link voltage is zero. When any leg command changes, the sequencer first opens the link switch and keeps the old bridge pattern until a programmed discharge delay has passed. It then applies the new pattern, with dead time inside each leg. When it closes the link again, it turns on both switches of leg 2 at the same time for a programmed precharge time. This stores energy in the resonant inductor for the next discharge. The nominal switching rate is 20 kHz, so every window fits many times into one carrier period.

The discharge delay, the minimum link-open width and the precharge time are 16-bit cycle counts. They are sampled when each sequence starts. The open window can be widened to act as a zero vector. A leg change that arrives while a sequence is running is remembered and starts the next sequence, so none is lost. After reset the block captures the current leg pattern before it closes the link for the first time.

Top module: `zvs_gate_seq`

## Requirements
- R1: While reset is low, and in the two cycles after the first rising edge with reset high, all six bridge gates and `link_gate` are low. `link_gate` is high from the third rising edge after reset release onward, as long as no leg change occurs.
- R2: At start-up, leg k drives its upper gate when `leg_cmd[k]` is 1 and its lower gate when it is 0. The commanded gate turns on `cfg_deadtime` cycles after the link first closes, and the opposite gate stays low.
- R3: A change in any `leg_cmd` bit that is sampled on rising edge k drives `link_gate` low after edge k+1. `link_gate` is still high in the cycle after edge k.
- R4: Number the link-open cycles from 0, where cycle 0 is the first cycle with `link_gate` low. With D the sampled discharge delay, the bridge gates keep their previous pattern through cycle D+1.
- R5: For each leg whose command changed, the outgoing gate is low from cycle D+2. The incoming gate is high from cycle D+2+T, where T is `cfg_deadtime`, and both gates of that leg are low in between.
- R6: `link_gate` stays low for exactly max(`cfg_linkoff`, D+T+3) cycles.
- R7: When the link closes, `gate_hi[2]` and `gate_lo[2]` are both high for max(`cfg_precharge`,1) cycles. After that, leg 2 follows its own command again.
- R8: A leg change that arrives while the link is open or during precharge starts a second sequence. Its cycle 0 is the cycle right after the single closed cycle that follows the first sequence.
- R9: Changing `cfg_discharge`, `cfg_linkoff` or `cfg_precharge` while a sequence runs leaves that sequence unchanged. The new values govern the next sequence.
- R10: No leg ever has both gates high, except leg 2 during precharge while `link_gate` is high.
- R11: A change of several legs in the same cycle produces a single open window. Afterwards the link stays closed and the gates stay steady until the next change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| leg_cmd | input | 3 | Raw PWM command per leg, 1 = upper switch on |
| cfg_discharge | input | 16 | Discharge delay in cycles |
| cfg_linkoff | input | 16 | Minimum link-open width in cycles |
| cfg_precharge | input | 16 | Leg-short precharge time in cycles (0 acts as 1) |
| cfg_deadtime | input | 16 | Dead time inside each leg in cycles, read live |
| gate_hi | output | 3 | Upper switch gate per leg |
| gate_lo | output | 3 | Lower switch gate per leg |
| link_gate | output | 1 | Series link switch gate |

## Verification
Two functions can meet in the same cycle. One is latching a new leg change. The other is the end of a running sequence, when the block drops back to the closed state and may start the next window. The bench provokes this by toggling a leg in the middle of an open window, after commutation has already taken the first value. It then requires the link to close for exactly one cycle after precharge and to reopen at once, with the second window commutating to the late value. The startup precharge also overlaps the dead-time countdown of the freshly captured pattern. The bench sweeps discharge, dead time, open width and precharge, and checks every cycle of each window against arithmetic expectations.

// File: rtl/zvs_seq_pkg.sv
// Package: shared state encoding for the gate sequencer.
// Assumes: nothing; type definitions only.
package zvs_seq_pkg;

    typedef enum logic [2:0] {
        ST_INIT,   // first cycle after reset, command sampler filling
        ST_CAPT,   // capture the first valid leg pattern
        ST_ARM,    // enable leg drivers, load precharge time
        ST_RUN,    // link closed, waiting for a leg change
        ST_OPEN,   // link open, discharge then commutate
        ST_PRECH   // link closed, one leg shorted to charge the inductor
    } seq_state_e;

endpackage

// File: rtl/zvs_cmd_sampler.sv
// Module: registers the raw leg commands and flags any change.
// Assumes: leg_cmd is already synchronous to clk; change is a one-cycle
// pulse in the cycle after a new value is first registered.
module zvs_cmd_sampler #(
    parameter int NLEG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLEG-1:0] leg_cmd,
    output logic [NLEG-1:0] cmd_q,
    output logic            change
);

    logic [NLEG-1:0] cmd_d;

    // Two-stage history of the commands for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            cmd_d <= '0;
        end else begin
            cmd_q <= leg_cmd;
            cmd_d <= cmd_q;
        end
    end

    // Per-leg change flags merged into one event.
    always_comb change = |(cmd_q ^ cmd_d);

endmodule

// File: rtl/zvs_link_fsm.sv
// Module: link-switch sequencer. It opens the link on a change, commutates
// after the discharge delay, recloses with a precharge short, and latches
// changes that arrive while a sequence is running.
// Assumes: dead time is read live; the other timings are sampled at the
// start of each sequence.
module zvs_link_fsm
    import zvs_seq_pkg::*;
#(
    parameter int NLEG  = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLEG-1:0]  cmd_q,
    input  logic             change,
    input  logic [CNT_W-1:0] cfg_discharge,
    input  logic [CNT_W-1:0] cfg_linkoff,
    input  logic [CNT_W-1:0] cfg_precharge,
    input  logic [CNT_W-1:0] cfg_deadtime,
    output logic [NLEG-1:0]  applied,
    output logic             legs_en,
    output logic             link_on,
    output logic             short_on
);

    localparam int CW = CNT_W + 2;

    seq_state_e       state;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    open_r;
    logic [CNT_W-1:0] dis_r;
    logic [CNT_W-1:0] pre_r;
    logic             pending;
    logic [CW-1:0]    need;
    logic [CW-1:0]    open_len;
    logic [CNT_W-1:0] pre_eff;

    // Open width: at least the programmed value, stretched so that the
    // dead time finishes inside the window.
    always_comb begin
        need     = CW'(cfg_discharge) + CW'(cfg_deadtime) + CW'(3);
        open_len = (CW'(cfg_linkoff) > need) ? CW'(cfg_linkoff) : need;
        pre_eff  = (cfg_precharge == '0) ? CNT_W'(1) : cfg_precharge;
    end

    // Sequencer state, window counter and sampled timings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_INIT;
            cnt     <= '0;
            open_r  <= '0;
            dis_r   <= '0;
            pre_r   <= '0;
            pending <= 1'b0;
            applied <= '0;
            legs_en <= 1'b0;
        end else begin
            case (state)
                ST_INIT: state <= ST_CAPT;
                ST_CAPT: begin
                    applied <= cmd_q;
                    state   <= ST_ARM;
                end
                ST_ARM: begin
                    if (change) pending <= 1'b1;
                    legs_en <= 1'b1;
                    pre_r   <= pre_eff;
                    cnt     <= '0;
                    state   <= ST_PRECH;
                end
                ST_RUN: begin
                    if (change || pending) begin
                        pending <= 1'b0;
                        dis_r   <= cfg_discharge;
                        open_r  <= open_len;
                        pre_r   <= pre_eff;
                        cnt     <= '0;
                        state   <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (change) pending <= 1'b1;
                    if (cnt == CW'(dis_r)) applied <= cmd_q;
                    if (cnt == open_r - CW'(1)) begin
                        cnt   <= '0;
                        state <= ST_PRECH;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PRECH: begin
                    if (change) pending <= 1'b1;
                    if (cnt == CW'(pre_r) - CW'(1)) begin
                        cnt   <= '0;
                        state <= ST_RUN;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= ST_INIT;
            endcase
        end
    end

    // Link drive and short request decoded from the state.
    always_comb begin
        link_on  = (state == ST_RUN) || (state == ST_PRECH);
        short_on = (state == ST_PRECH);
    end

endmodule

// File: rtl/zvs_leg_deadtime.sv
// Module: one bridge leg. It picks the upper or lower gate from the
// wanted side and blanks both gates for the dead time on every side change.
// Assumes: while en is low the gates are off and the dead time is re-armed,
// so the first turn-on after enable also waits out the dead time.
module zvs_leg_deadtime #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             want,
    input  logic [CNT_W-1:0] dead,
    output logic             gate_hi,
    output logic             gate_lo
);

    logic             side_q;
    logic [CNT_W-1:0] blank;

    // Track the wanted side and count the blanking interval down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= 1'b0;
            blank  <= '0;
        end else if (!en || (side_q != want)) begin
            side_q <= want;
            blank  <= dead;
        end else if (blank != '0) begin
            blank <= blank - CNT_W'(1);
        end
    end

    // Drive the selected gate only once blanking has expired.
    always_comb begin
        gate_hi = en && side_q && (blank == '0);
        gate_lo = en && !side_q && (blank == '0);
    end

endmodule

// File: rtl/zvs_gate_seq.sv
// Module: top of the gate sequencer. It joins the command sampler, the
// link sequencer and one dead-time unit per leg, and forces both gates of
// the shorting leg on during precharge.
// Assumes: NLEG legs, with SHORT_LEG inside 0..NLEG-1.
module zvs_gate_seq #(
    parameter int NLEG      = 3,
    parameter int CNT_W     = 16,
    parameter int SHORT_LEG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLEG-1:0]  leg_cmd,
    input  logic [CNT_W-1:0] cfg_discharge,
    input  logic [CNT_W-1:0] cfg_linkoff,
    input  logic [CNT_W-1:0] cfg_precharge,
    input  logic [CNT_W-1:0] cfg_deadtime,
    output logic [NLEG-1:0]  gate_hi,
    output logic [NLEG-1:0]  gate_lo,
    output logic             link_gate
);

    logic [NLEG-1:0] cmd_q;
    logic            change;
    logic [NLEG-1:0] applied;
    logic            legs_en;
    logic            link_on;
    logic            short_on;

    zvs_cmd_sampler #(.NLEG(NLEG)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .leg_cmd (leg_cmd),
        .cmd_q   (cmd_q),
        .change  (change)
    );

    zvs_link_fsm #(.NLEG(NLEG), .CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_q         (cmd_q),
        .change        (change),
        .cfg_discharge (cfg_discharge),
        .cfg_linkoff   (cfg_linkoff),
        .cfg_precharge (cfg_precharge),
        .cfg_deadtime  (cfg_deadtime),
        .applied       (applied),
        .legs_en       (legs_en),
        .link_on       (link_on),
        .short_on      (short_on)
    );

    // One dead-time unit per leg; the shorting leg gets the override.
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        logic hi_raw;
        logic lo_raw;

        zvs_leg_deadtime #(.CNT_W(CNT_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (legs_en),
            .want    (applied[g]),
            .dead    (cfg_deadtime),
            .gate_hi (hi_raw),
            .gate_lo (lo_raw)
        );

        if (g == SHORT_LEG) begin : g_short
            assign gate_hi[g] = hi_raw | short_on;
            assign gate_lo[g] = lo_raw | short_on;
        end else begin : g_plain
            assign gate_hi[g] = hi_raw;
            assign gate_lo[g] = lo_raw;
        end
    end

    assign link_gate = link_on;

endmodule

// File: rtl/zvs_gate_seq_chk.sv
// Module: property checker for the gate sequencer, bound to the top.
// Assumes: port-level view only, plus one local flag that records the
// first link opening.
module zvs_gate_seq_chk #(
    parameter int NLEG      = 3,
    parameter int CNT_W     = 16,
    parameter int SHORT_LEG = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NLEG-1:0]  gate_hi,
    input logic [NLEG-1:0]  gate_lo,
    input logic             link_gate,
    input logic [CNT_W-1:0] cfg_deadtime
);

    localparam logic [NLEG-1:0] SMASK = NLEG'(1) << SHORT_LEG;

    logic link_q;
    logic opened_q;

    // Record that the link has opened at least once since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q   <= 1'b0;
            opened_q <= 1'b0;
        end else begin
            link_q <= link_gate;
            if (link_q && !link_gate) opened_q <= 1'b1;
        end
    end

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & gate_lo & ~SMASK) == '0));

    assert_short_needs_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi[SHORT_LEG] && gate_lo[SHORT_LEG]) |-> link_gate);

    assert_hold_on_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_gate) |-> ((gate_hi == $past(gate_hi)) && (gate_lo == $past(gate_lo))));

    assert_precharge_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_gate) |-> (gate_hi[SHORT_LEG] && gate_lo[SHORT_LEG]));

    assert_steady_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (opened_q && link_gate && $past(link_gate)) |->
            (((gate_hi & ~SMASK) == ($past(gate_hi) & ~SMASK)) &&
             ((gate_lo & ~SMASK) == ($past(gate_lo) & ~SMASK))));

    for (genvar g = 0; g < NLEG; g++) begin : g_gap
        if (g != SHORT_LEG) begin : g_chk
            assert_dead_gap_hl_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (($past(cfg_deadtime) != '0) && $past(gate_hi[g]) && !$past(gate_lo[g]))
                    |-> !gate_lo[g]);
            assert_dead_gap_lh_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (($past(cfg_deadtime) != '0) && $past(gate_lo[g]) && !$past(gate_hi[g]))
                    |-> !gate_hi[g]);
        end
    end

endmodule

bind zvs_gate_seq zvs_gate_seq_chk #(
    .NLEG      (NLEG),
    .CNT_W     (CNT_W),
    .SHORT_LEG (SHORT_LEG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_hi      (gate_hi),
    .gate_lo      (gate_lo),
    .link_gate    (link_gate),
    .cfg_deadtime (cfg_deadtime)
);

// File: tb/tb_zvs_gate_seq.sv
`timescale 1ns/1ps
// Bench: sweeps the timing settings and checks every cycle of the startup
// and of each open/precharge window against arithmetic expectations.
module tb_zvs_gate_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  leg_cmd = '0;
    logic [15:0] cfg_discharge = '0;
    logic [15:0] cfg_linkoff = '0;
    logic [15:0] cfg_precharge = '0;
    logic [15:0] cfg_deadtime = '0;
    logic [2:0]  gate_hi;
    logic [2:0]  gate_lo;
    logic        link_gate;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int D, OFF, DT, P;
    logic [2:0] cur;

    always #2 clk = ~clk;

    zvs_gate_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .leg_cmd       (leg_cmd),
        .cfg_discharge (cfg_discharge),
        .cfg_linkoff   (cfg_linkoff),
        .cfg_precharge (cfg_precharge),
        .cfg_deadtime  (cfg_deadtime),
        .gate_hi       (gate_hi),
        .gate_lo       (gate_lo),
        .link_gate     (link_gate)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected state of one gate in cycle i of an open window.
    function automatic bit exp_on(input int leg, input bit upper, input int i,
                                  input logic [2:0] oc, input logic [2:0] nc,
                                  input int l, input int pe);
        bit was_on, will_on;
        if (leg == 2 && i >= l && i < l + pe) return 1'b1;
        was_on  = upper ? oc[leg] : !oc[leg];
        will_on = upper ? nc[leg] : !nc[leg];
        if (oc[leg] == nc[leg]) return was_on;
        if (was_on) return (i <= D + 1);
        return (i >= D + 2 + DT);
    endfunction

    task automatic no_overlap(input string tag);
        chk(((gate_hi & gate_lo & 3'b011) == 0) && (!(gate_hi[2] && gate_lo[2]) || link_gate),
            tag, "overlap", {gate_hi, gate_lo}, 0);
    endtask

    task automatic set_cfg;
        cfg_discharge = 16'(D);
        cfg_linkoff   = 16'(OFF);
        cfg_precharge = 16'(P);
        cfg_deadtime  = 16'(DT);
    endtask

    // Reset, then check the startup capture and precharge (R1, R2, R7).
    task automatic startup(input logic [2:0] pat);
        int pe;
        rst_n = 1'b0;
        leg_cmd = pat;
        set_cfg();
        repeat (3) @(negedge clk);
        chk(gate_hi == 0 && gate_lo == 0 && !link_gate, "R1", "in reset",
            {gate_hi, gate_lo, link_gate}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(gate_hi == 0 && gate_lo == 0 && !link_gate, "R1", "before capture",
                {gate_hi, gate_lo, link_gate}, 0);
        end
        pe = imax(P, 1);
        for (int i = 0; i <= imax(pe, DT) + 1; i++) begin
            logic [2:0] eh, el;
            @(negedge clk);
            for (int g = 0; g < 3; g++) begin
                if (g == 2 && i < pe) begin
                    eh[g] = 1'b1; el[g] = 1'b1;
                end else begin
                    eh[g] = pat[g] && (i >= DT);
                    el[g] = !pat[g] && (i >= DT);
                end
            end
            chk(link_gate, "R1", "link after capture", link_gate, 1);
            chk(gate_hi == eh && gate_lo == el, (i < pe) ? "R7" : "R2", "startup gates",
                {gate_hi, gate_lo}, {eh, el});
            no_overlap("R10");
        end
        cur = pat;
    endtask

    // Drive one leg change and check the whole window cycle by cycle.
    task automatic do_event(input logic [2:0] nc, input bit chained, input int mid_idx,
                            input logic [2:0] mid_cmd, input bit mid_cfg, input bit idle,
                            input string tag);
        int l, pe;
        logic [2:0] oc;
        oc = cur;
        l  = imax(OFF, D + DT + 3);
        pe = imax(P, 1);
        if (!chained) begin
            leg_cmd = nc;
            @(negedge clk);
            chk(link_gate, "R3", "link before open", link_gate, 1);
        end
        for (int i = 0; i <= l + pe; i++) begin
            logic [2:0] eh, el;
            string lt, gt;
            @(negedge clk);
            for (int g = 0; g < 3; g++) begin
                eh[g] = exp_on(g, 1'b1, i, oc, nc, l, pe);
                el[g] = exp_on(g, 1'b0, i, oc, nc, l, pe);
            end
            lt = (i == 0) ? "R3" : ((i >= l && i < l + pe) ? "R7" : "R6");
            gt = (i >= l && i < l + pe) ? "R7" : ((i <= D + 1) ? "R4" : ((i < l) ? "R5" : "R11"));
            if (tag != "") begin lt = tag; gt = tag; end
            chk(link_gate == (i >= l), lt, "link", link_gate, (i >= l));
            chk(gate_hi == eh, gt, "gate_hi", gate_hi, eh);
            chk(gate_lo == el, gt, "gate_lo", gate_lo, el);
            no_overlap("R10");
            if (i == mid_idx) leg_cmd = mid_cmd;
            if (i == 1 && mid_cfg) begin
                cfg_discharge = 16'(D + 2);
                cfg_linkoff   = 16'(OFF + 7);
                cfg_precharge = 16'(P + 2);
            end
        end
        cur = nc;
        if (mid_cfg) begin
            D = D + 2; OFF = OFF + 7; P = P + 2;
        end
        if (idle) begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                chk(link_gate && gate_hi == cur && gate_lo == ~cur, "R11", "steady after window",
                    {link_gate, gate_hi, gate_lo}, {1'b1, cur, ~cur});
            end
        end
    endtask

    initial begin
        int offs[3];
        int pres[3];
        offs = '{0, 4, 11};
        pres = '{0, 1, 3};
        for (int d = 0; d < 4; d++) begin
            for (int t = 0; t < 3; t++) begin
                for (int o = 0; o < 3; o++) begin
                    for (int p = 0; p < 3; p++) begin
                        D = d; DT = t; OFF = offs[o]; P = pres[p];
                        startup(3'b010);
                        do_event(3'b101, 1'b0, -1, 3'b000, 1'b0, 1'b1, "");
                        do_event(3'b100, 1'b0, -1, 3'b000, 1'b0, 1'b1, "");
                        do_event(3'b110, 1'b0, -1, 3'b000, 1'b0, 1'b1, "");
                        do_event(3'b011, 1'b0, -1, 3'b000, 1'b0, 1'b1, "");
                    end
                end
            end
        end
        // R8: late change inside an open window chains a second window.
        D = 1; DT = 1; OFF = 9; P = 2;
        startup(3'b000);
        do_event(3'b011, 1'b0, 5, 3'b010, 1'b0, 1'b0, "R8");
        do_event(3'b010, 1'b1, -1, 3'b000, 1'b0, 1'b1, "R8");
        // R9: timing changes mid-window only affect the following window.
        do_event(3'b101, 1'b0, -1, 3'b000, 1'b1, 1'b1, "R9");
        do_event(3'b000, 1'b0, -1, 3'b000, 1'b0, 1'b1, "R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule